// File: doc/BRIEF.md
# Paged Address Translator

This block turns a 16-bit logical address into a 24-bit physical address. Memory is split into 256-byte pages. The upper byte of the logical address selects an entry in an on-chip page table. That entry supplies a 16-bit frame number. The physical address is that frame number with the unchanged low byte placed beneath it.

A bound register holds the highest page number the running process may touch. Each request gets exactly one answer one cycle later, and the answer is one of three:

- a completed translation;
- a range trap, when the page lies above the bound;
- a fault trap, when the page is within the bound but its entry is not marked resident.

Software-side logic fills the table through a synchronous write port and sets the bound through a load port. It then issues requests with a one-cycle strobe.

Top module: `page_xlat`

## Requirements
- R1: On a completed translation, `phys_addr` equals the 16-bit frame number of the selected entry in bits 23:8, with logical bits 7:0 copied unchanged into bits 7:0. For example, logical 0x02FE maps to 0x01A0FE when entry 0x02 holds frame 0x01A0 and is resident.
- R2: A request whose page number (logical bits 15:8) is greater than the current bound raises `trap_range` one cycle later.
- R3: A request whose page number is at or below the bound, and whose entry is not resident, raises `trap_fault` one cycle later.
- R4: When a page is above the bound, `trap_range` is raised and `trap_fault` and `xlat_done` stay low, whatever the residency of its entry.
- R5: Every strobe is answered in the following cycle by exactly one of `xlat_done`, `trap_range` or `trap_fault` pulsing high. In a cycle that follows no strobe, all three are low.
- R6: A table write in one cycle, setting the frame and the resident flag, is seen by any request strobed in a later cycle. This includes clearing the resident flag, after which the page faults.
- R7: After reset, every table entry is non-resident and the bound is 0x00. Until the bound is raised, only page 0x00 is in range.
- R8: A bound load takes effect for requests in later cycles. A page equal to the bound is in range.
- R9: Page 0xFF with bound 0xFF translates normally, so the top frame and top offset reach `phys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation strobe, one cycle per request |
| req_laddr | input | 16 | Logical address |
| bound_we | input | 1 | Load enable for the highest legal page |
| bound_wdata | input | 8 | New highest legal page |
| pt_we | input | 1 | Page table write enable |
| pt_wpage | input | 8 | Page table entry to write |
| pt_wframe | input | 16 | Frame number to store |
| pt_wres | input | 1 | Resident flag to store |
| xlat_done | output | 1 | Translation completed pulse |
| phys_addr | output | 24 | Physical address, meaningful with `xlat_done` |
| trap_range | output | 1 | Page above the bound |
| trap_fault | output | 1 | Page in range but not resident |

## Verification
The bench builds the block with its default widths: 16-bit logical, 24-bit physical and 8-bit offset. With these widths the full 256-entry table and the extreme page 0xFF are small enough to visit directly. That lets the bench sweep every page after reset to confirm that each one faults. It also lets the bench drive the bound to both ends of its range. Together these reach the boundary where a page equals the bound, the top-page translation, and the case where a page is above the bound yet resident.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_DONE  = 2'd1,
    OUT_RANGE = 2'd2,
    OUT_FAULT = 2'd3
  } xlat_out_e;
endpackage

// File: rtl/page_xlat_frame_ram.sv
module page_xlat_frame_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single-clock RAM, no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_xlat_res_bits.sv
module page_xlat_res_bits #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] res_q;

  // Flop array so that reset clears every resident flag at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      rbit  <= 1'b0;
    end else begin
      if (we) res_q[waddr] <= wbit;
      if (re) rbit <= res_q[raddr];
    end
  end
endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import page_xlat_pkg::*;
#(
  parameter int LA_W  = 16,
  parameter int PA_W  = 24,
  parameter int OFF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [LA_W-1:0]       req_laddr,
  input  logic                  bound_we,
  input  logic [LA_W-OFF_W-1:0] bound_wdata,
  input  logic                  pt_we,
  input  logic [LA_W-OFF_W-1:0] pt_wpage,
  input  logic [PA_W-OFF_W-1:0] pt_wframe,
  input  logic                  pt_wres,
  output logic                  xlat_done,
  output logic [PA_W-1:0]       phys_addr,
  output logic                  trap_range,
  output logic                  trap_fault
);
  localparam int PG_W = LA_W - OFF_W;
  localparam int FR_W = PA_W - OFF_W;

  logic [PG_W-1:0]  bound_q;
  logic [PG_W-1:0]  req_page;
  logic             req_q;
  logic             in_range_q;
  logic [OFF_W-1:0] off_q;
  logic [FR_W-1:0]  frame_rd;
  logic             res_rd;
  xlat_out_e        outcome;

  assign req_page = req_laddr[LA_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst) bound_q <= '0;
    else if (bound_we) bound_q <= bound_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      in_range_q <= 1'b0;
      off_q      <= '0;
    end else begin
      req_q      <= req_valid;
      in_range_q <= (req_page <= bound_q);
      off_q      <= req_laddr[OFF_W-1:0];
    end
  end

  page_xlat_frame_ram #(.ADDR_W(PG_W), .DATA_W(FR_W)) u_frames (
    .clk   (clk),
    .we    (pt_we),
    .waddr (pt_wpage),
    .wdata (pt_wframe),
    .re    (req_valid),
    .raddr (req_page),
    .rdata (frame_rd)
  );

  page_xlat_res_bits #(.ADDR_W(PG_W)) u_res (
    .clk   (clk),
    .rst   (rst),
    .we    (pt_we),
    .waddr (pt_wpage),
    .wbit  (pt_wres),
    .re    (req_valid),
    .raddr (req_page),
    .rbit  (res_rd)
  );

  // Range check outranks the residency check.
  always_comb begin
    if (!req_q)           outcome = OUT_NONE;
    else if (!in_range_q) outcome = OUT_RANGE;
    else if (!res_rd)     outcome = OUT_FAULT;
    else                  outcome = OUT_DONE;
  end

  assign xlat_done  = (outcome == OUT_DONE);
  assign trap_range = (outcome == OUT_RANGE);
  assign trap_fault = (outcome == OUT_FAULT);
  assign phys_addr  = {frame_rd, off_q};
endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int LA_W  = 16,
  parameter int PA_W  = 24,
  parameter int OFF_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [LA_W-1:0]       req_laddr,
  input logic                  bound_we,
  input logic [LA_W-OFF_W-1:0] bound_wdata,
  input logic                  pt_we,
  input logic [LA_W-OFF_W-1:0] pt_wpage,
  input logic [PA_W-OFF_W-1:0] pt_wframe,
  input logic                  pt_wres,
  input logic                  xlat_done,
  input logic [PA_W-1:0]       phys_addr,
  input logic                  trap_range,
  input logic                  trap_fault
);
  localparam int PG_W = LA_W - OFF_W;

  logic [PG_W-1:0] bound_m;
  always_ff @(posedge clk) begin
    if (rst) bound_m <= '0;
    else if (bound_we) bound_m <= bound_wdata;
  end

  logic [PG_W-1:0] pg;
  assign pg = req_laddr[LA_W-1:OFF_W];

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !$past(rst)) |=> (!xlat_done || phys_addr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0])));

  a_r2_above_bound: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pg > bound_m) |=> trap_range);

  a_r8_within_bound: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pg <= bound_m) |=> !trap_range);

  a_r4_one_answer: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xlat_done, trap_range, trap_fault}));

  a_r5_answered: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ($countones({xlat_done, trap_range, trap_fault}) == 1));

  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(xlat_done || trap_range || trap_fault));

  a_r6_write_seen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pt_we) && $past(pt_wres) && req_valid &&
     pg == $past(pt_wpage) && pg <= bound_m)
    |=> (xlat_done && phys_addr[PA_W-1:OFF_W] == $past(pt_wframe, 2)));

  a_r6_clear_seen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pt_we) && !$past(pt_wres) && req_valid &&
     pg == $past(pt_wpage) && pg <= bound_m) |=> trap_fault);
endmodule

bind page_xlat page_xlat_chk #(.LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/page_xlat_bench.sv
module page_xlat_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [15:0] req_laddr;
  logic        bound_we;
  logic [7:0]  bound_wdata;
  logic        pt_we;
  logic [7:0]  pt_wpage;
  logic [15:0] pt_wframe;
  logic        pt_wres;
  logic        xlat_done;
  logic [23:0] phys_addr;
  logic        trap_range;
  logic        trap_fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [2:0] K_NONE  = 3'b000;
  localparam logic [2:0] K_DONE  = 3'b100;
  localparam logic [2:0] K_RANGE = 3'b010;
  localparam logic [2:0] K_FAULT = 3'b001;

  always #2 clk = ~clk;

  page_xlat u_page_xlat (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; bound_we = 0; pt_we = 0;
  endtask

  task automatic wr_entry(input logic [7:0] pg, input logic [15:0] fr, input logic res);
    @(negedge clk);
    pt_we = 1; pt_wpage = pg; pt_wframe = fr; pt_wres = res;
    @(negedge clk);
    pt_we = 0;
  endtask

  task automatic set_bound(input logic [7:0] b);
    @(negedge clk);
    bound_we = 1; bound_wdata = b;
    @(negedge clk);
    bound_we = 0;
  endtask

  task automatic xlat(input logic [15:0] la, input logic [2:0] kind,
                      input logic [23:0] pa, input string tag);
    @(negedge clk);
    req_valid = 1; req_laddr = la;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " kind"}, {29'd0, xlat_done, trap_range, trap_fault}, {29'd0, kind});
    if (kind == K_DONE) chk({tag, " addr"}, {8'd0, phys_addr}, {8'd0, pa});
  endtask

  task automatic t_reset();
    rst = 1; idle();
    req_laddr = 0; bound_wdata = 0; pt_wpage = 0; pt_wframe = 0; pt_wres = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R7 outputs low", {29'd0, xlat_done, trap_range, trap_fault}, 32'd0);
    xlat(16'h0010, K_FAULT, 0, "R7 page0 in range after reset");
    xlat(16'h0100, K_RANGE, 0, "R7 bound is zero");
    set_bound(8'hFF);
    begin
      int bad = 0;
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        req_valid = 1; req_laddr = {p[7:0], 8'h5A};
        @(negedge clk);
        req_valid = 0;
        if (!trap_fault || xlat_done || trap_range) bad++;
      end
      chk("R7 all pages non-resident", bad, 0);
    end
  endtask

  task automatic t_basic();
    wr_entry(8'h02, 16'h01A0, 1);
    xlat(16'h02FE, K_DONE, 24'h01A0FE, "R1 example");
    wr_entry(8'h35, 16'hBEEF, 1);
    xlat(16'h3500, K_DONE, 24'hBEEF00, "R1 offset zero");
    xlat(16'h35FF, K_DONE, 24'hBEEFFF, "R1 offset top");
    xlat(16'h3601, K_FAULT, 0, "R3 untouched page");
  endtask

  task automatic t_bound();
    wr_entry(8'h10, 16'h0A0A, 1);
    set_bound(8'h10);
    xlat(16'h1044, K_DONE, 24'h0A0A44, "R8 page equals bound");
    xlat(16'h1144, K_RANGE, 0, "R2 page above bound");
    xlat(16'h0F44, K_FAULT, 0, "R3 below bound not resident");
  endtask

  task automatic t_priority();
    wr_entry(8'h40, 16'h4444, 1);
    xlat(16'h4012, K_RANGE, 0, "R4 resident above bound");
    xlat(16'h8012, K_RANGE, 0, "R4 non-resident above bound");
  endtask

  task automatic t_update();
    @(negedge clk);
    pt_we = 1; pt_wpage = 8'h05; pt_wframe = 16'h1111; pt_wres = 1;
    @(negedge clk);
    pt_we = 0; req_valid = 1; req_laddr = 16'h0577;
    @(negedge clk);
    req_valid = 0;
    chk("R6 next-cycle write seen", {xlat_done, phys_addr}, {1'b1, 24'h111177});
    wr_entry(8'h05, 16'h1111, 0);
    xlat(16'h0577, K_FAULT, 0, "R6 cleared entry faults");
    wr_entry(8'h05, 16'h2222, 1);
    xlat(16'h0501, K_DONE, 24'h222201, "R6 rewritten frame");
  endtask

  task automatic t_stream();
    @(negedge clk);
    req_valid = 1; req_laddr = 16'h0203;
    @(negedge clk);
    req_laddr = 16'h2003;
    chk("R5 first of pair", {xlat_done, phys_addr}, {1'b1, 24'h01A003});
    @(negedge clk);
    req_valid = 0;
    chk("R5 second of pair", {29'd0, xlat_done, trap_range, trap_fault}, {29'd0, K_RANGE});
    @(negedge clk);
    chk("R5 quiet after strobe", {29'd0, xlat_done, trap_range, trap_fault}, {29'd0, K_NONE});
  endtask

  task automatic t_top();
    set_bound(8'hFF);
    wr_entry(8'hFF, 16'hFFFF, 1);
    xlat(16'hFFAB, K_DONE, 24'hFFFFAB, "R9 top page");
    xlat(16'h4012, K_DONE, 24'h444412, "R8 raised bound admits page");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bound();
    t_priority();
    t_update();
    t_stream();
    t_top();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end
endmodule